// File: doc/BRIEF.md
# Write Data Lane Steering

This block sits between a 64-bit bus-side write datapath and a write buffer that feeds double-data-rate output registers. Each memory word is 128 bits wide and holds two 64-bit slots: slot 0 (word bits 63:0) is sent on the rising edge, and slot 1 (word bits 127:64) is sent on the falling edge of one memory clock. The block places each incoming 64-bit write beat into the correct slot and builds complete 128-bit words. It presents each finished word as four 32-bit lanes, and each lane has its own write enable.

A transfer opens with a one-cycle start pulse that carries bit 3 of the starting byte address. This pulse may arrive with the first beat or on an earlier cycle. If bit 3 is clear, the first beat fills the rising slot. If bit 3 is set, the first beat fills the falling slot. From then on the slots alternate with each valid beat. A word is released when its falling slot has been filled, or when the final beat of the transfer arrives. Lanes that were never written in a partial word keep their enable low, so the downstream mask logic can suppress them. Single-DWORD writes use the per-DWORD enables of the beat to write only one lane.

Top module: `wr_lane_steer`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, word_done_o is 0, lane_we_o is 0 and word_data_o is 0.
- R2: A valid beat that coincides with start_i goes to the slot given by addr3_i (0: word bits 63:0; 1: word bits 127:64). A beat into slot 1 completes the word, so a start with addr3_i=1 yields a word with lanes 0 and 1 unwritten.
- R3: Each valid beat without start_i goes to the slot after the one used by the previous valid beat (0 then 1, 1 then 0). Cycles with beat_valid_i low do not move the slot.
- R4: For a beat in slot s, beat bits 31:0 go to lane 2s and beat bits 63:32 go to lane 2s+1. Lane k occupies word_data_o bits 32k+31:32k. A beat half is written only when its bit in beat_dw_en_i (bit 0 = low half, bit 1 = high half) is 1.
- R5: word_done_o is 1 for exactly one cycle, in the cycle after a valid beat that fills slot 1 or carries last_i. At all other times it is 0.
- R6: When word_done_o is 1, bit k of lane_we_o is 1 exactly when lane k was written in that word. When word_done_o is 0, lane_we_o is 0.
- R7: Lanes of a completed word that were not written read as zero in word_data_o.
- R8: word_data_o keeps its value in every cycle where word_done_o is 0.
- R9: A start_i pulse with beat_valid_i low produces no word. It only sets the slot for the next valid beat from addr3_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transfer start pulse; samples addr3_i |
| addr3_i | input | 1 | Bit 3 of the starting byte address |
| beat_valid_i | input | 1 | Beat data valid |
| beat_data_i | input | 64 | Write beat data |
| beat_dw_en_i | input | 2 | Per-DWORD enables of the beat |
| last_i | input | 1 | Beat is the final beat of the transfer |
| word_data_o | output | 128 | Assembled word, four 32-bit lanes |
| lane_we_o | output | 4 | Per-lane write enables of the released word |
| word_done_o | output | 1 | Word-complete strobe |

## Verification
The assertions assume that a transfer always ends with a beat that carries last_i, or with a beat into slot 1, before the next start_i arrives. They also assume that start_i is never held over more than one cycle of the same transfer. The bench respects both assumptions. Its random transfers have a length between one and six beats, raise start_i only with or before the first beat, and always put last_i on the final beat. Idle gaps of random length are inserted between beats, and the DWORD enables take every value, including zero.

// File: rtl/wls_pkg.sv
package wls_pkg;
  typedef enum logic {
    SLOT_RISE = 1'b0,
    SLOT_FALL = 1'b1
  } slot_e;

  localparam int unsigned NUM_SLOTS = 2;
endpackage

// File: rtl/wls_slot_ptr.sv
module wls_slot_ptr
  import wls_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  addr3_i,
  input  logic  beat_valid_i,
  input  logic  last_i,
  output slot_e cur_slot_o,
  output logic  word_end_o
);
  slot_e ptr_q;

  always_comb begin
    cur_slot_o = start_i ? slot_e'(addr3_i) : ptr_q;
    word_end_o = beat_valid_i & ((cur_slot_o == SLOT_FALL) | last_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ptr_q <= SLOT_RISE;
    else if (beat_valid_i) ptr_q <= (cur_slot_o == SLOT_RISE) ? SLOT_FALL : SLOT_RISE;
    else if (start_i)      ptr_q <= slot_e'(addr3_i);
  end
endmodule

// File: rtl/wls_lane.sv
module wls_lane #(
  parameter int unsigned LANE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [LANE_W-1:0] data_i,
  input  logic              clr_i,
  output logic [LANE_W-1:0] merged_data_o,
  output logic              merged_we_o
);
  logic [LANE_W-1:0] acc_q;
  logic              we_q;

  // merged view includes the current beat so a completing word needs no extra cycle
  always_comb begin
    merged_data_o = wr_i ? data_i : acc_q;
    merged_we_o   = wr_i | we_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      we_q  <= 1'b0;
    end else if (clr_i) begin
      acc_q <= '0;
      we_q  <= 1'b0;
    end else if (wr_i) begin
      acc_q <= data_i;
      we_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/wls_out_reg.sv
module wls_out_reg #(
  parameter int unsigned WORD_W    = 128,
  parameter int unsigned NUM_LANES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 word_end_i,
  input  logic [WORD_W-1:0]    merged_data_i,
  input  logic [NUM_LANES-1:0] merged_we_i,
  output logic [WORD_W-1:0]    word_data_o,
  output logic [NUM_LANES-1:0] lane_we_o,
  output logic                 word_done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_data_o <= '0;
      lane_we_o   <= '0;
      word_done_o <= 1'b0;
    end else begin
      word_done_o <= word_end_i;
      lane_we_o   <= word_end_i ? merged_we_i : '0;
      if (word_end_i) word_data_o <= merged_data_i;
    end
  end
endmodule

// File: rtl/wr_lane_steer.sv
module wr_lane_steer
  import wls_pkg::*;
#(
  parameter int unsigned BEAT_W = 64,
  parameter int unsigned LANE_W = 32
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  start_i,
  input  logic                                  addr3_i,
  input  logic                                  beat_valid_i,
  input  logic [BEAT_W-1:0]                     beat_data_i,
  input  logic [BEAT_W/LANE_W-1:0]              beat_dw_en_i,
  input  logic                                  last_i,
  output logic [NUM_SLOTS*BEAT_W-1:0]           word_data_o,
  output logic [NUM_SLOTS*(BEAT_W/LANE_W)-1:0]  lane_we_o,
  output logic                                  word_done_o
);
  localparam int unsigned PER_BEAT  = BEAT_W / LANE_W;
  localparam int unsigned NUM_LANES = NUM_SLOTS * PER_BEAT;
  localparam int unsigned WORD_W    = NUM_SLOTS * BEAT_W;

  slot_e                cur_slot;
  logic                 word_end;
  logic [WORD_W-1:0]    merged_data;
  logic [NUM_LANES-1:0] merged_we;

  wls_slot_ptr u_ptr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .addr3_i      (addr3_i),
    .beat_valid_i (beat_valid_i),
    .last_i       (last_i),
    .cur_slot_o   (cur_slot),
    .word_end_o   (word_end)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam logic        LSLOT = 1'(g / PER_BEAT);
    localparam int unsigned LHALF = g % PER_BEAT;
    logic wr;
    assign wr = beat_valid_i & (cur_slot == slot_e'(LSLOT)) & beat_dw_en_i[LHALF];

    wls_lane #(.LANE_W(LANE_W)) u_lane (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .wr_i          (wr),
      .data_i        (beat_data_i[LHALF*LANE_W +: LANE_W]),
      .clr_i         (word_end),
      .merged_data_o (merged_data[g*LANE_W +: LANE_W]),
      .merged_we_o   (merged_we[g])
    );
  end

  wls_out_reg #(.WORD_W(WORD_W), .NUM_LANES(NUM_LANES)) u_out (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .word_end_i    (word_end),
    .merged_data_i (merged_data),
    .merged_we_i   (merged_we),
    .word_data_o   (word_data_o),
    .lane_we_o     (lane_we_o),
    .word_done_o   (word_done_o)
  );
endmodule

// File: rtl/wr_lane_steer_chk.sv
module wr_lane_steer_chk #(
  parameter int unsigned WORD_W    = 128,
  parameter int unsigned NUM_LANES = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic                 addr3_i,
  input logic                 beat_valid_i,
  input logic                 last_i,
  input logic [WORD_W-1:0]    word_data_o,
  input logic [NUM_LANES-1:0] lane_we_o,
  input logic                 word_done_o
);
  p_idle_we_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_done_o |-> lane_we_o == '0);

  p_hold_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_done_o |-> $stable(word_data_o));

  p_fall_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_i && start_i && addr3_i) |=> word_done_o);

  p_last_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_i && last_i) |=> word_done_o);

  p_no_beat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_valid_i |=> !word_done_o);

  p_upper_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_i && start_i && addr3_i) |=> lane_we_o[NUM_LANES/2-1:0] == '0);

  p_lower_open_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_i && start_i && !addr3_i && !last_i) |=> !word_done_o);
endmodule

bind wr_lane_steer wr_lane_steer_chk #(.WORD_W(WORD_W), .NUM_LANES(NUM_LANES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .addr3_i      (addr3_i),
  .beat_valid_i (beat_valid_i),
  .last_i       (last_i),
  .word_data_o  (word_data_o),
  .lane_we_o    (lane_we_o),
  .word_done_o  (word_done_o)
);

// File: tb/wr_lane_steer_tb.sv
module wr_lane_steer_tb;
  localparam int BW = 64;
  localparam int LW = 32;
  localparam int WW = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, a3 = 1'b0, valid = 1'b0, last = 1'b0;
  logic [BW-1:0] data = '0;
  logic [1:0]    en = '0;
  logic [WW-1:0] word_data;
  logic [3:0]    lane_we;
  logic          done;

  int checks = 0;
  int failures = 0;
  string cur_tag = "R4";

  // bench-side model state
  logic          m_ptr = 1'b0;
  logic [WW-1:0] m_acc = '0;
  logic [3:0]    m_we = '0;
  logic          e_done = 1'b0;
  logic [3:0]    e_we = '0;
  logic [WW-1:0] e_data = '0;

  always #2 clk = ~clk;

  wr_lane_steer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr3_i(a3),
    .beat_valid_i(valid), .beat_data_i(data), .beat_dw_en_i(en), .last_i(last),
    .word_data_o(word_data), .lane_we_o(lane_we), .word_done_o(done)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 1'b0; m_acc = '0; m_we = '0;
      e_done = 1'b0; e_we = '0; e_data = '0;
    end else begin
      logic cs;
      cs = start ? a3 : m_ptr;
      if (valid) begin
        for (int h = 0; h < 2; h++) begin
          if (en[h]) begin
            m_acc[(2*cs+h)*LW +: LW] = data[h*LW +: LW];
            m_we[2*cs+h] = 1'b1;
          end
        end
        if (cs || last) begin
          e_done = 1'b1; e_we = m_we; e_data = m_acc;
          m_acc = '0; m_we = '0;
        end else begin
          e_done = 1'b0; e_we = '0;
        end
        m_ptr = ~cs;
      end else begin
        e_done = 1'b0; e_we = '0;
        if (start) m_ptr = a3;
      end
    end
  end

  task automatic chk(bit ok, string tag, string what, logic [WW-1:0] act, logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(done == e_done, "R5", "word_done", WW'(done), WW'(e_done));
    chk(lane_we == e_we, "R6", "lane_we", WW'(lane_we), WW'(e_we));
    chk(word_data == e_data, e_done ? cur_tag : "R8", "word_data", word_data, e_data);
  endtask

  // drive at negedge, then compare after the next posedge has registered
  task automatic step(bit s, bit ad, bit v, logic [BW-1:0] d, logic [1:0] e, bit l);
    start = s; a3 = ad; valid = v; data = d; en = e; last = l;
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, '0, 2'b00, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && lane_we == '0 && word_data == '0, "R1", "reset state",
        {word_data[WW-6:0], lane_we, done}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && lane_we == '0 && word_data == '0, "R1", "after release",
        {word_data[WW-6:0], lane_we, done}, '0);

    // R2: start in falling slot, single beat completes the word
    cur_tag = "R2";
    step(1, 1, 1, 64'hA1A1_A1A1_B2B2_B2B2, 2'b11, 0);
    chk(lane_we == 4'b1100 && word_data[63:0] == '0, "R2", "upper start",
        WW'({lane_we, word_data[63:0]}), WW'({4'b1100, 64'h0}));
    idle();

    // R3: alternation with an idle gap, then odd start
    cur_tag = "R3";
    step(1, 0, 1, 64'h1111_1111_2222_2222, 2'b11, 0);
    idle();
    step(0, 0, 1, 64'h3333_3333_4444_4444, 2'b11, 0);
    chk(word_data == {64'h3333_3333_4444_4444, 64'h1111_1111_2222_2222}, "R3", "pair",
        word_data, {64'h3333_3333_4444_4444, 64'h1111_1111_2222_2222});
    step(1, 1, 1, 64'h5555_5555_6666_6666, 2'b11, 0);
    step(0, 0, 1, 64'h7777_7777_8888_8888, 2'b11, 0);
    step(0, 0, 1, 64'h9999_9999_AAAA_AAAA, 2'b11, 1);
    chk(word_data == {64'h9999_9999_AAAA_AAAA, 64'h7777_7777_8888_8888}, "R3", "after odd",
        word_data, {64'h9999_9999_AAAA_AAAA, 64'h7777_7777_8888_8888});
    idle();

    // R7: DWORD write, only lane 0
    cur_tag = "R7";
    step(1, 0, 1, 64'hDEAD_BEEF_CAFE_F00D, 2'b01, 1);
    chk(lane_we == 4'b0001 && word_data == WW'(64'hCAFE_F00D), "R7", "dword lane 0",
        word_data, WW'(64'hCAFE_F00D));
    idle();

    // R9: start alone, beat follows later
    cur_tag = "R9";
    step(1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 0);
    chk(done == 1'b0, "R9", "start only", WW'(done), '0);
    idle();
    step(0, 0, 1, 64'h0123_4567_89AB_CDEF, 2'b10, 0);
    chk(lane_we == 4'b1000 && word_data == {32'h0123_4567, 96'h0}, "R9", "deferred slot",
        word_data, {32'h0123_4567, 96'h0});
    idle();

    // R4: random transfers
    cur_tag = "R4";
    for (int t = 0; t < 300; t++) begin
      int len;
      bit ad;
      len = $urandom_range(6, 1);
      ad = 1'($urandom_range(1, 0));
      for (int b = 0; b < len; b++) begin
        int gap;
        logic [1:0] e;
        gap = $urandom_range(2, 0);
        for (int g = 0; g < gap; g++) idle();
        e = ($urandom_range(3, 0) == 0) ? 2'($urandom_range(3, 0)) : 2'b11;
        step(b == 0, ad, 1'b1, {$urandom, $urandom}, e, b == len - 1);
      end
      if ($urandom_range(1, 0) == 1) idle();
    end
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule